// File: doc/BRIEF.md
# Chip-Select Frame Edge Detector

This block takes an active-low chip-select line from an external serial master, which runs with no fixed phase to the local system clock, and moves it into the clock domain through a chain of synchronizing flip-flops. It compares the synchronized level with its value one clock earlier. From that comparison it produces a one-cycle frame-start pulse when the line goes low and a one-cycle frame-end pulse when it goes high.

A sticky flag records that at least one frame has started, so a slow indicator such as an LED can show the event. A one-cycle clear input or the synchronous reset lowers the flag. Every synchronizer and history register resets to the idle-high level of the line. A line held high through and after reset therefore never reports a spurious frame start.

Top module: `cs_edge_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs_n_sync` reads 1, `frame_start` and `frame_end` read 0, and `start_flag` reads 0.
- R2: With `cs_n_async` held at 1 through and after reset, no `frame_start` or `frame_end` pulse ever occurs.
- R3: A falling transition of `cs_n_async` first captured at rising clock edge E1 raises `frame_start` after edge E3 and lowers it again after E4. That is two synchronizer stages plus one history stage.
- R4: A rising transition first captured at edge E1 raises `frame_end` after edge E3 and lowers it after E4.
- R5: Each pulse is exactly one clock cycle wide, and `frame_start` and `frame_end` are never high in the same cycle.
- R6: `cs_n_sync` takes the level of `cs_n_async` captured at edge E1 starting after edge E2.
- R7: Starts and ends alternate after reset, beginning with a start. A low phase that is captured for even a single clock edge yields one start followed by one end.
- R8: `start_flag` goes to 1 in the cycle after a `frame_start` pulse and keeps that value through later frame ends.
- R9: `start_flag` goes to 0 in the cycle after `flag_clr` is sampled high. If `flag_clr` and `frame_start` are high in the same cycle, the flag ends up at 1.
- R10: A low glitch on `cs_n_async` that lies wholly between two rising clock edges produces no pulse and leaves `start_flag` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n_async | input | 1 | Active-low chip-select, asynchronous to clk |
| flag_clr | input | 1 | Clears the sticky frame-start flag |
| frame_start | output | 1 | One-cycle pulse on a synchronized falling transition |
| frame_end | output | 1 | One-cycle pulse on a synchronized rising transition |
| cs_n_sync | output | 1 | Chip-select level after the synchronizer chain |
| start_flag | output | 1 | Sticky record that a frame start occurred |

## Verification
The sticky flag can be told to set and to clear on the same clock edge. The bench provokes this by raising `flag_clr` exactly over the cycle in which `frame_start` is high. It expects the flag to read 1 afterwards. A plain clear one cycle later must drop the flag to 0. Around this, the bench sweeps every sub-cycle phase of the chip-select transitions over several low-phase lengths and predicts each pulse cycle from the edge count.

// File: rtl/cs_edge_detect.sv
module cs_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_async,
  input  logic flag_clr,
  output logic frame_start,
  output logic frame_end,
  output logic cs_n_sync,
  output logic start_flag
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         hist_q;
  logic         start_q, end_q, flag_q;

  assign cs_n_sync   = sync_q[MSB];
  assign frame_start = start_q;
  assign frame_end   = end_q;
  assign start_flag  = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      hist_q  <= 1'b1;
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[MSB-1:0], cs_n_async};
      hist_q  <= sync_q[MSB];
      start_q <= hist_q & ~sync_q[MSB];
      end_q   <= ~hist_q & sync_q[MSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (start_q) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  logic in_frame_q;
  always_ff @(posedge clk) begin
    if (rst)              in_frame_q <= 1'b0;
    else if (frame_start) in_frame_q <= 1'b1;
    else if (frame_end)   in_frame_q <= 1'b0;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start); // R5
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) frame_end |=> !frame_end); // R5
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst) !(frame_start && frame_end)); // R5
  AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) frame_start |-> (!$past(cs_n_sync) && $past(cs_n_sync, 2))); // R3
  AST_END_AFTER_RISE: assert property (@(posedge clk) disable iff (rst) frame_end |-> ($past(cs_n_sync) && !$past(cs_n_sync, 2))); // R4
  AST_ALTERNATE_START: assert property (@(posedge clk) disable iff (rst) frame_start |-> !in_frame_q); // R7
  AST_ALTERNATE_END: assert property (@(posedge clk) disable iff (rst) frame_end |-> in_frame_q); // R7
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst) frame_start |=> start_flag); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst) (flag_clr && !frame_start) |=> !start_flag); // R9

endmodule

// File: tb/sim_cs_edge_detect.sv
module sim_cs_edge_detect;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n_async = 1'b1;
  logic flag_clr = 1'b0;
  logic frame_start, frame_end, cs_n_sync, start_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  cs_edge_detect u0 (
    .clk(clk), .rst(rst), .cs_n_async(cs_n_async), .flag_clr(flag_clr),
    .frame_start(frame_start), .frame_end(frame_end),
    .cs_n_sync(cs_n_sync), .start_flag(start_flag)
  );

  always #(HALF) clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // low phase captured at `hold` edges, falling transition `off` ns after an edge
  task automatic frame(int off, int hold);
    @(posedge clk);
    fork
      begin
        #(off) cs_n_async = 1'b0;
        repeat (hold) @(posedge clk);
        #(off) cs_n_async = 1'b1;
      end
      begin
        for (int k = 1; k <= hold + 4; k++) begin
          @(posedge clk);
          #(HALF);
          chk("R3", frame_start, k == 3);
          chk("R4", frame_end, k == 3 + hold);
          chk("R6", cs_n_sync, !(k >= 2 && k < 2 + hold));
          if (k == 4) chk("R8", start_flag, 1'b1);
        end
      end
    join
  endtask

  initial begin
    #(PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 / R2: reset with line idle high
    repeat (3) @(posedge clk);
    #(HALF);
    chk("R1", cs_n_sync, 1'b1);
    chk("R1", frame_start, 1'b0);
    chk("R1", frame_end, 1'b0);
    chk("R1", start_flag, 1'b0);
    @(posedge clk); #1 rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #(HALF);
      chk("R2", frame_start, 1'b0);
      chk("R2", frame_end, 1'b0);
      chk("R2", start_flag, 1'b0);
      chk("R1", cs_n_sync, 1'b1);
    end

    // R3..R8: every phase, several low-phase lengths (R7 pairs at hold=1)
    for (int hold = 1; hold <= 5; hold++)
      for (int off = 1; off < PERIOD; off++) begin
        frame(off, hold);
        repeat (2) @(posedge clk);
      end
    for (int n = 0; n < 20; n++) begin
      frame($urandom_range(PERIOD - 1, 1), $urandom_range(6, 1));
      @(posedge clk);
    end
    #(HALF);
    chk("R8", start_flag, 1'b1);

    // R9: plain clear
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    #(HALF);
    chk("R9", start_flag, 1'b0);

    // R10: glitch wholly between edges
    @(posedge clk); #3 cs_n_async = 1'b0; #3 cs_n_async = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #(HALF);
      chk("R10", frame_start, 1'b0);
      chk("R10", frame_end, 1'b0);
      chk("R10", start_flag, 1'b0);
    end

    // R9: clear coincides with start pulse, set wins
    @(posedge clk);
    #2 cs_n_async = 1'b0;
    @(posedge clk);              // E1
    @(posedge clk);              // E2
    @(posedge clk); #1 flag_clr = 1'b1;  // E3: pulse high
    #(HALF);
    chk("R3", frame_start, 1'b1);
    @(posedge clk); #1 flag_clr = 1'b0;  // E4
    #(HALF);
    chk("R9", start_flag, 1'b1);
    chk("R5", frame_start, 1'b0);
    @(posedge clk); #1 flag_clr = 1'b1;
    @(posedge clk); #1 flag_clr = 1'b0;
    #(HALF);
    chk("R9", start_flag, 1'b0);
    cs_n_async = 1'b1;
    repeat (5) @(posedge clk);
    #(HALF);
    chk("R8", start_flag, 1'b0);

    finish_run();
  end
endmodule